// File: doc/BRIEF.md
# SMBus Timeout and Bus-Idle Detector

This block watches the synchronized levels of the two bus lines and enforces SMBus timing limits. It has two programmable 12-bit limits. Limit A runs a single window counter. Depending on a mode input, the counter measures either how long the clock line stays low (low-timeout mode) or how long both lines stay high (bus-idle mode). Limit B measures a cumulative total: the clock-low time that this device itself adds by stretching, counted while the protocol engine marks the device as holding the clock low. That total is cleared on every START and every STOP.

Both limits count in ticks of `TICK_DIV` core clocks, and a limit value of L fires after (L+1) ticks. When a limit fires, the block sets a sticky timeout flag and drives an interrupt line while the error-interrupt enable is high. It also pulses one recovery request, chosen by the current role: a STOP request when acting as master, or a release request for both lines when acting as slave. Software clears the flag with a write-one-to-clear strobe.

The limit-A side is a four-state machine. **A_OFF** is entered whenever its enable is low. **A_ARMED** is entered when the monitored condition is false. **A_COUNT** accumulates while the condition holds. **A_SPENT** is entered on the firing cycle and held until the condition breaks. The limit-B side also has four states. **B_OFF** means the check is disabled. **B_IDLE** means the total is kept but the device is not stretching, and it is also entered on START/STOP, which clears the total. **B_HOLD** means the device is stretching and the total grows. **B_SPENT** is entered when the limit fires and is left only on START/STOP or on disable. The flag is a two-state machine, **FLAG_CLEAR** and **FLAG_SET**. A firing moves it to FLAG_SET, and a clear strobe without a firing in the same cycle moves it to FLAG_CLEAR.

Top module: `smb_tmo_guard`

## Requirements
- R1: With `idle_mode`=0 and `a_en`=1, the flag is set after the clock edge that samples the Nth consecutive cycle of `scl_i`=0, where N=(`a_limit`+1)·`TICK_DIV`. It is not set one cycle earlier.
- R2: A single cycle of the monitored condition being false restarts the limit-A count from zero. A continuous run fires at most once.
- R3: With `idle_mode`=1, the count runs only while `scl_i`=1 and `sda_i`=1, and fires after N consecutive such cycles. Either line low restarts it.
- R4: With `b_en`=1, every cycle with `self_hold`=1 adds to a total that survives gaps. When the total reaches (`b_limit`+1)·`TICK_DIV`, a timeout fires.
- R5: A timeout that fires while `role_master`=0 pulses `release_req` and does not pulse `stop_req`.
- R6: `start_det` or `stop_det` clears the limit-B total and wins over `self_hold` in the same cycle. After limit B fires, it cannot fire again until START or STOP.
- R7: `tmo_flag` stays set until a `flag_clr` cycle. A firing in the same cycle as `flag_clr` leaves the flag set.
- R8: `tmo_irq` is high exactly when `tmo_flag`=1 and `err_ie`=1.
- R9: Each firing gives a one-cycle pulse on `stop_req` when `role_master`=1, or on `release_req` otherwise. This applies to both limits, in the same cycle the flag sets.
- R10: A disabled check holds its count at zero. Re-enabling it restarts the count from zero.
- R11: After reset, `tmo_flag`, `tmo_irq`, `stop_req` and `release_req` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized clock-line level |
| sda_i | input | 1 | Synchronized data-line level |
| idle_mode | input | 1 | 0: limit A measures clock low; 1: limit A measures both lines high |
| a_en | input | 1 | Enable for the limit-A check |
| a_limit | input | LIMIT_W | Limit A in ticks minus one |
| b_en | input | 1 | Enable for the cumulative-stretch check |
| b_limit | input | LIMIT_W | Limit B in ticks minus one |
| role_master | input | 1 | 1: device acts as master; 0: slave |
| self_hold | input | 1 | Device is currently holding the clock line low |
| start_det | input | 1 | One-cycle START seen on the bus |
| stop_det | input | 1 | One-cycle STOP seen on the bus |
| err_ie | input | 1 | Error-interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| tmo_flag | output | 1 | Sticky timeout flag |
| tmo_irq | output | 1 | Interrupt request |
| stop_req | output | 1 | One-cycle request to generate a STOP |
| release_req | output | 1 | One-cycle request to release both lines |

## Verification
A window count that is off by one, or that fails to restart, shows up as a flag and a recovery pulse exactly one cycle early or late. The bench's behavioural model catches this on the first firing after the fault. A limit-B total that is not cleared on START/STOP, or that leaks counts during gaps, moves the firing cycle of the next stretch sequence. A spent state that fails to hold shows up as a second recovery pulse while the condition persists. A wrong role decode or a failed set-over-clear priority shows up at the ports in the firing cycle itself. The outputs are compared with the model on every clock, so each such fault is reported no later than one cycle after the affected edge.

// File: rtl/smb_tmo_pkg.sv
package smb_tmo_pkg;

    typedef enum logic [1:0] {
        A_OFF,
        A_ARMED,
        A_COUNT,
        A_SPENT
    } win_state_t;

    typedef enum logic [1:0] {
        B_OFF,
        B_IDLE,
        B_HOLD,
        B_SPENT
    } ext_state_t;

    typedef enum logic {
        FLAG_CLEAR,
        FLAG_SET
    } flag_state_t;

endpackage

// File: rtl/smb_tick_cnt.sv
// Two-level counter: a fine stage of TICK_DIV core cycles and a coarse tick stage.
module smb_tick_cnt #(
    parameter int LIMIT_W  = 12,
    parameter int TICK_DIV = 2048
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    input  logic [LIMIT_W-1:0] limit,
    output logic               at_limit
);
    localparam int FINE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [FINE_W-1:0] FINE_LAST = FINE_W'(TICK_DIV - 1);

    logic [FINE_W-1:0]  fine_q;
    logic [LIMIT_W-1:0] coarse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fine_q   <= '0;
            coarse_q <= '0;
        end else if (clr) begin
            fine_q   <= '0;
            coarse_q <= '0;
        end else if (inc) begin
            if (fine_q == FINE_LAST) begin
                fine_q   <= '0;
                coarse_q <= coarse_q + 1'b1;
            end else begin
                fine_q <= fine_q + 1'b1;
            end
        end
    end

    // Current count value is the last cycle of the final tick.
    always_comb begin
        at_limit = (fine_q == FINE_LAST) && (coarse_q == limit);
    end

endmodule

// File: rtl/smb_win_fsm.sv
// Limit-A window: continuous-condition timer (clock low or bus idle).
module smb_win_fsm
    import smb_tmo_pkg::*;
#(
    parameter int LIMIT_W  = 12,
    parameter int TICK_DIV = 2048
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               cond,
    input  logic [LIMIT_W-1:0] limit,
    output logic               hit
);
    win_state_t state_q, state_d;
    logic       cnt_clr, cnt_inc, cnt_last;

    smb_tick_cnt #(
        .LIMIT_W (LIMIT_W),
        .TICK_DIV(TICK_DIV)
    ) win_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .limit   (limit),
        .at_limit(cnt_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= A_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        hit     = 1'b0;
        if (!en) begin
            state_d = A_OFF;
            cnt_clr = 1'b1;
        end else if (!cond) begin
            state_d = A_ARMED;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                A_OFF, A_ARMED, A_COUNT: begin
                    cnt_inc = 1'b1;
                    if (cnt_last) begin
                        hit     = 1'b1;
                        state_d = A_SPENT;
                    end else begin
                        state_d = A_COUNT;
                    end
                end
                A_SPENT: state_d = A_SPENT;
                default: state_d = A_OFF;
            endcase
        end
    end

    // R2
    spent_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == A_SPENT) |-> $past(cond));

    // R10
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> (state_q == A_OFF));

endmodule

// File: rtl/smb_ext_fsm.sv
// Limit-B: cumulative self-stretch accumulator, cleared on START/STOP.
module smb_ext_fsm
    import smb_tmo_pkg::*;
#(
    parameter int LIMIT_W  = 12,
    parameter int TICK_DIV = 2048
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               hold,
    input  logic               restart,
    input  logic [LIMIT_W-1:0] limit,
    output logic               hit
);
    ext_state_t state_q, state_d;
    logic       cnt_clr, cnt_inc, cnt_last;

    smb_tick_cnt #(
        .LIMIT_W (LIMIT_W),
        .TICK_DIV(TICK_DIV)
    ) ext_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .inc     (cnt_inc),
        .limit   (limit),
        .at_limit(cnt_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= B_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        hit     = 1'b0;
        if (!en) begin
            state_d = B_OFF;
            cnt_clr = 1'b1;
        end else if (restart) begin
            state_d = B_IDLE;
            cnt_clr = 1'b1;
        end else begin
            unique case (state_q)
                B_OFF, B_IDLE, B_HOLD: begin
                    if (hold) begin
                        cnt_inc = 1'b1;
                        if (cnt_last) begin
                            hit     = 1'b1;
                            state_d = B_SPENT;
                        end else begin
                            state_d = B_HOLD;
                        end
                    end else begin
                        state_d = B_IDLE;
                    end
                end
                B_SPENT: state_d = B_SPENT;
                default: state_d = B_OFF;
            endcase
        end
    end

    // R6
    restart_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en && restart)) |-> (state_q == B_IDLE));

    // R4
    hold_state_tracks_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_HOLD) |-> $past(hold));

    // R10
    spent_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == B_SPENT) |-> $past(en));

endmodule

// File: rtl/smb_tmo_guard.sv
module smb_tmo_guard
    import smb_tmo_pkg::*;
#(
    parameter int LIMIT_W  = 12,
    parameter int TICK_DIV = 2048
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic               idle_mode,
    input  logic               a_en,
    input  logic [LIMIT_W-1:0] a_limit,
    input  logic               b_en,
    input  logic [LIMIT_W-1:0] b_limit,
    input  logic               role_master,
    input  logic               self_hold,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               err_ie,
    input  logic               flag_clr,
    output logic               tmo_flag,
    output logic               tmo_irq,
    output logic               stop_req,
    output logic               release_req
);
    logic        win_cond, win_hit, ext_hit, any_hit;
    flag_state_t flag_q, flag_d;
    logic        stop_q, rel_q;

    always_comb begin
        win_cond = idle_mode ? (scl_i & sda_i) : ~scl_i;
        any_hit  = win_hit | ext_hit;
    end

    smb_win_fsm #(
        .LIMIT_W (LIMIT_W),
        .TICK_DIV(TICK_DIV)
    ) win_i (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (a_en),
        .cond (win_cond),
        .limit(a_limit),
        .hit  (win_hit)
    );

    smb_ext_fsm #(
        .LIMIT_W (LIMIT_W),
        .TICK_DIV(TICK_DIV)
    ) ext_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (b_en),
        .hold   (self_hold),
        .restart(start_det | stop_det),
        .limit  (b_limit),
        .hit    (ext_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= FLAG_CLEAR;
            stop_q <= 1'b0;
            rel_q  <= 1'b0;
        end else begin
            flag_q <= flag_d;
            stop_q <= any_hit & role_master;
            rel_q  <= any_hit & ~role_master;
        end
    end

    always_comb begin
        flag_d = flag_q;
        unique case (flag_q)
            FLAG_CLEAR: if (any_hit) flag_d = FLAG_SET;
            FLAG_SET:   if (flag_clr && !any_hit) flag_d = FLAG_CLEAR;
            default:    flag_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        tmo_flag    = (flag_q == FLAG_SET);
        tmo_irq     = tmo_flag & err_ie;
        stop_req    = stop_q;
        release_req = rel_q;
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !flag_clr) |=> tmo_flag);

    // R7
    recovery_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req || release_req) |-> tmo_flag);

    // R9
    one_recovery_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_req && release_req));

endmodule

// File: tb/smb_tmo_guard_tb_top.sv
module smb_tmo_guard_tb_top;
    localparam int LW  = 12;
    localparam int DIV = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_i = 1'b1, sda_i = 1'b1, idle_mode = 1'b0;
    logic a_en = 1'b0, b_en = 1'b0;
    logic [LW-1:0] a_limit = 12'd3, b_limit = 12'd4;
    logic role_master = 1'b0, self_hold = 1'b0;
    logic start_det = 1'b0, stop_det = 1'b0, err_ie = 1'b0, flag_clr = 1'b0;
    logic tmo_flag, tmo_irq, stop_req, release_req;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    string cur_tag = "R11";

    always #4 clk = ~clk;

    smb_tmo_guard #(.LIMIT_W(LW), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .idle_mode(idle_mode), .a_en(a_en), .a_limit(a_limit),
        .b_en(b_en), .b_limit(b_limit), .role_master(role_master),
        .self_hold(self_hold), .start_det(start_det), .stop_det(stop_det),
        .err_ie(err_ie), .flag_clr(flag_clr), .tmo_flag(tmo_flag),
        .tmo_irq(tmo_irq), .stop_req(stop_req), .release_req(release_req)
    );

    // Behavioural reference model
    int m_runA = 0;
    int m_accB = 0;
    bit m_flag = 0, m_stop = 0, m_rel = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_runA = 0; m_accB = 0;
            m_flag = 0; m_stop = 0; m_rel = 0;
        end else begin
            bit hit;
            bit condA;
            hit   = 0;
            condA = idle_mode ? (scl_i && sda_i) : !scl_i;
            if (a_en && condA) begin
                m_runA++;
                if (m_runA == (int'(a_limit) + 1) * DIV) hit = 1;
            end else begin
                m_runA = 0;
            end
            if (!b_en || start_det || stop_det) begin
                m_accB = 0;
            end else if (self_hold) begin
                m_accB++;
                if (m_accB == (int'(b_limit) + 1) * DIV) hit = 1;
            end
            m_stop = hit && role_master;
            m_rel  = hit && !role_master;
            if (hit) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk({cur_tag, " flag/model"}, tmo_flag, m_flag);
            chk({"R8 irq/model ", cur_tag}, tmo_irq, m_flag && err_ie);
            chk({"R9 stop/model ", cur_tag}, stop_req, m_stop);
            chk({"R9 release/model ", cur_tag}, release_req, m_rel);
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R11 flag", tmo_flag, 1'b0);
        chk("R11 irq", tmo_irq, 1'b0);
        chk("R11 stop", stop_req, 1'b0);
        chk("R11 release", release_req, 1'b0);

        // R1: low timeout, master role
        cur_tag = "R1";
        a_en = 1'b1; role_master = 1'b1; err_ie = 1'b1;
        scl_i = 1'b0;
        tick(63);
        chk("R1 not yet", tmo_flag, 1'b0);
        tick(1);
        chk("R1 fired", tmo_flag, 1'b1);
        chk("R9 stop pulse", stop_req, 1'b1);
        chk("R9 no release", release_req, 1'b0);
        chk("R8 irq on", tmo_irq, 1'b1);
        tick(1);
        chk("R9 stop one cycle", stop_req, 1'b0);
        cur_tag = "R2";
        tick(100);
        chk("R2 fires once", stop_req, 1'b0);
        // R7 clear
        cur_tag = "R7";
        clear_flag();
        chk("R7 cleared", tmo_flag, 1'b0);
        chk("R8 irq off", tmo_irq, 1'b0);
        err_ie = 1'b0;

        // R2: restart on break
        cur_tag = "R2";
        scl_i = 1'b1; tick(1);
        scl_i = 1'b0; tick(50);
        scl_i = 1'b1; tick(1);
        scl_i = 1'b0; tick(50);
        chk("R2 restarted", tmo_flag, 1'b0);
        tick(13);
        chk("R2 edge-1", tmo_flag, 1'b0);
        tick(1);
        chk("R2 fired", tmo_flag, 1'b1);
        chk("R8 masked", tmo_irq, 1'b0);
        clear_flag();
        scl_i = 1'b1;

        // R3: bus idle mode, slave role
        cur_tag = "R3";
        idle_mode = 1'b1; role_master = 1'b0; sda_i = 1'b0;
        tick(5);
        sda_i = 1'b1; tick(40);
        sda_i = 1'b0; tick(1);
        sda_i = 1'b1;
        tick(63);
        chk("R3 not yet", tmo_flag, 1'b0);
        tick(1);
        chk("R3 idle fired", tmo_flag, 1'b1);
        chk("R5 release pulse", release_req, 1'b1);
        chk("R5 no stop", stop_req, 1'b0);
        a_en = 1'b0; idle_mode = 1'b0;
        clear_flag();

        // R4: cumulative stretch, master
        cur_tag = "R4";
        b_en = 1'b1; role_master = 1'b1;
        self_hold = 1'b1; tick(30);
        self_hold = 1'b0; tick(10);
        self_hold = 1'b1; tick(30);
        self_hold = 1'b0; tick(10);
        self_hold = 1'b1; tick(19);
        chk("R4 not yet", tmo_flag, 1'b0);
        tick(1);
        chk("R4 fired", tmo_flag, 1'b1);
        chk("R4 stop pulse", stop_req, 1'b1);
        clear_flag();
        cur_tag = "R6";
        tick(100);
        chk("R6 spent holds", tmo_flag, 1'b0);

        // R6: START/STOP clear the total
        start_det = 1'b1; tick(1); start_det = 1'b0;
        role_master = 1'b0;
        tick(70);
        stop_det = 1'b1; tick(1); stop_det = 1'b0;
        tick(79);
        chk("R6 cleared by stop", tmo_flag, 1'b0);
        tick(1);
        chk("R6 fired after clear", tmo_flag, 1'b1);
        chk("R5 release", release_req, 1'b1);
        self_hold = 1'b0; b_en = 1'b0;
        clear_flag();

        // R10: disable holds count at zero
        cur_tag = "R10";
        a_en = 1'b1; scl_i = 1'b0; tick(40);
        a_en = 1'b0; tick(5);
        a_en = 1'b1; tick(63);
        chk("R10 restarted", tmo_flag, 1'b0);
        tick(1);
        chk("R10 fired", tmo_flag, 1'b1);
        clear_flag();
        scl_i = 1'b1; tick(2);

        // R7: set wins over clear
        cur_tag = "R7";
        flag_clr = 1'b1;
        scl_i = 1'b0; tick(64);
        chk("R7 set wins", tmo_flag, 1'b1);
        tick(1);
        chk("R7 cleared next", tmo_flag, 1'b0);
        flag_clr = 1'b0; scl_i = 1'b1; a_en = 1'b0;
        tick(3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule